// File: doc/BRIEF.md
# Pairwise Dot-Product Interaction Unit

This unit forms the second-order feature interactions of one sample in a recommendation network. Each sample arrives as a stream of vectors that all have the same length: first the dense vector produced by the bottom MLP, then the pooled embedding vectors in table order. The unit stores the whole sample, computes the dot product of every unordered pair of distinct vectors, and streams out one output word per element or pair. The output is the dense vector followed by the upper-triangle dot products, with the self products and the mirror-image duplicates left out. That output is the input row of the top MLP.

Storage is double-buffered. A second sample can load while the first is still being computed and drained. Each dot product goes through a bank of parallel multiply-accumulate lanes and takes a fixed number of cycles. The accumulator keeps full precision. Its result is then shifted and cut down to the output word width.

Top module: `ixn_unit`

## Requirements
- R1: An input vector is accepted on a clock edge where `in_valid` and `in_ready` are both high. Element e of the vector sits at bits [e*DW +: DW] as a signed value. The first vector of a sample is the dense vector (index 0), and the next NUM_TABLES vectors are the embedding vectors 1..NUM_TABLES, in that order.
- R2: Each sample's output begins with DIM words that carry the dense elements 0..DIM-1 in order, each sign-extended to OUT_W bits.
- R3: After the dense words come NUM_TABLES*(NUM_TABLES+1)/2 pair words, one for each pair (i,j) with i<j. They are ordered by i ascending and then by j ascending. No word is produced for i=j, and no word is produced for i>j.
- R4: A pair word is the sum over all elements of the signed products, taken at 2*DW+clog2(DIM) bits, arithmetically shifted right by OUT_SHIFT, keeping the low OUT_W bits.
- R5: `out_last` is high on the final pair word of each sample and on no other word.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R7: Two samples can be stored at once. A second sample is accepted while the first is still unfinished at the output. While two unfinished samples are stored, `in_ready` is low.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: With `out_ready` held high, consecutive accepted words of the same sample that lead into a pair word are DIM/LANES+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector is valid |
| in_ready | output | 1 | A free buffer can take the vector |
| in_data | input | DIM*DW | One input vector, element e at [e*DW +: DW] |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | OUT_W | Dense element or pair dot product |
| out_last | output | 1 | Final word of the sample |

## Verification
The checker watches the output handshake on every cycle. It checks that a stalled word stays stable, that `out_last` falls exactly on the last word of each sample's word count, and that no more than two samples' worth of vectors are ever held. Only the bench's scenarios can show that the words carry the right values in the right pair order, including wrap-around at the output width from extreme inputs. The same holds for the fixed per-pair compute spacing and for the ping-pong behaviour, where a second sample loads while the output is stalled.

// File: rtl/ixn_pkg.sv
// Shared types for the interaction unit.
// Assumes: nothing beyond the standard.
package ixn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DENSE,
        ST_MAC,
        ST_PAIR
    } eng_state_t;
endpackage

// File: rtl/ixn_bank.sv
// Ping-pong sample store: two buffers of V vectors each.
// Loads one vector per accepted beat and marks a buffer full after V beats.
// Offers two combinational read ports into one chosen buffer.
// Assumes: the engine releases only a buffer it has finished reading.
module ixn_bank #(
    parameter int V   = 4,
    parameter int DIM = 4,
    parameter int DW  = 16,
    localparam int VW = (V > 1) ? $clog2(V) : 1,
    localparam int BW = DIM * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [BW-1:0] in_data,
    output logic          in_ready,
    input  logic          rd_buf,
    input  logic [VW-1:0] rd_idx_a,
    input  logic [VW-1:0] rd_idx_b,
    output logic [BW-1:0] rd_vec_a,
    output logic [BW-1:0] rd_vec_b,
    input  logic          release_buf,
    output logic [1:0]    full
);
    logic [BW-1:0] mem [2*V];
    logic          wr_sel;
    logic [VW-1:0] wcnt;
    logic          accept;
    logic          load_done;

    assign in_ready  = !full[wr_sel];
    assign accept    = in_valid && in_ready;
    assign load_done = accept && (wcnt == VW'(V - 1));

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (accept) mem[int'(wr_sel) * V + int'(wcnt)] <= in_data;
    end

    // Write pointer and buffer occupancy flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel <= 1'b0;
            wcnt   <= '0;
            full   <= 2'b00;
        end else begin
            if (accept) begin
                if (load_done) begin
                    wcnt   <= '0;
                    wr_sel <= ~wr_sel;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
            end
            for (int b = 0; b < 2; b++) begin
                full[b] <= (full[b] && !(release_buf && (rd_buf == b[0])))
                         || (load_done && (wr_sel == b[0]));
            end
        end
    end

    // Read ports for the engine.
    always_comb begin
        rd_vec_a = mem[int'(rd_buf) * V + int'(rd_idx_a)];
        rd_vec_b = mem[int'(rd_buf) * V + int'(rd_idx_b)];
    end
endmodule

// File: rtl/ixn_pair_seq.sv
// Walks the strict upper triangle (i<j) in row-major order.
// Assumes: V >= 2; step is not issued once last is high.
module ixn_pair_seq #(
    parameter int V  = 4,
    localparam int VW = (V > 1) ? $clog2(V) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    output logic [VW-1:0] idx_i,
    output logic [VW-1:0] idx_j,
    output logic          last
);
    // Pair index registers.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            idx_i <= '0;
            idx_j <= VW'(1);
        end else if (step) begin
            if (idx_j == VW'(V - 1)) begin
                idx_i <= idx_i + 1'b1;
                idx_j <= idx_i + VW'(2);
            end else begin
                idx_j <= idx_j + 1'b1;
            end
        end
    end

    assign last = (idx_i == VW'(V - 2)) && (idx_j == VW'(V - 1));
endmodule

// File: rtl/ixn_mac.sv
// Multiply-accumulate lanes: adds LANES signed products per enabled cycle.
// On the first chunk of a dot product the old sum is dropped.
// Assumes: ACC_W is wide enough for the full dot product.
module ixn_mac #(
    parameter int LANES = 2,
    parameter int DW    = 16,
    parameter int ACC_W = 34,
    localparam int CW   = LANES * DW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic [CW-1:0]           a,
    input  logic [CW-1:0]           b,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [2*DW-1:0]  prod [LANES];
    logic signed [ACC_W-1:0] chunk_sum;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // One signed multiplier per lane.
        assign prod[l] = $signed(a[l*DW +: DW]) * $signed(b[l*DW +: DW]);
    end

    // Adder tree over the lanes.
    always_comb begin
        chunk_sum = '0;
        for (int l = 0; l < LANES; l++) chunk_sum = chunk_sum + ACC_W'(prod[l]);
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (en)   acc <= first ? chunk_sum : acc + chunk_sum;
    end
endmodule

// File: rtl/ixn_unit.sv
// Pairwise dot-product interaction unit (top).
// Streams the dense vector, then every i<j dot product of the stored sample.
// Assumes: NUM_TABLES >= 1, DIM divisible by LANES, DW <= OUT_W <= ACC_W.
module ixn_unit
    import ixn_pkg::*;
#(
    parameter int NUM_TABLES = 3,
    parameter int DIM        = 4,
    parameter int DW         = 16,
    parameter int LANES      = 2,
    parameter int OUT_W      = 32,
    parameter int OUT_SHIFT  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DIM*DW-1:0]  in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OUT_W-1:0]   out_data,
    output logic               out_last
);
    localparam int V      = NUM_TABLES + 1;
    localparam int VW     = (V > 1) ? $clog2(V) : 1;
    localparam int CHUNKS = DIM / LANES;
    localparam int KW     = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
    localparam int EW     = (DIM > 1) ? $clog2(DIM) : 1;
    localparam int ACC_W  = 2 * DW + $clog2(DIM);
    localparam int LW     = LANES * DW;

    eng_state_t        state;
    logic              rd_sel;
    logic [EW-1:0]     ecnt;
    logic [KW-1:0]     chunk;
    logic [1:0]        full;
    logic [DIM*DW-1:0] vec_a, vec_b;
    logic [VW-1:0]     pi, pj;
    logic              plast;
    logic              hs;
    logic              seq_restart, seq_step, mac_en, release_buf;
    logic signed [ACC_W-1:0] acc, shifted;
    logic [DW-1:0]     dense_elem;

    ixn_bank #(.V(V), .DIM(DIM), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .rd_buf(rd_sel), .rd_idx_a(pi), .rd_idx_b(pj),
        .rd_vec_a(vec_a), .rd_vec_b(vec_b),
        .release_buf(release_buf), .full(full)
    );

    ixn_pair_seq #(.V(V)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .restart(seq_restart), .step(seq_step),
        .idx_i(pi), .idx_j(pj), .last(plast)
    );

    ixn_mac #(.LANES(LANES), .DW(DW), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n),
        .en(mac_en), .first(chunk == '0),
        .a(vec_a[int'(chunk) * LW +: LW]),
        .b(vec_b[int'(chunk) * LW +: LW]),
        .acc(acc)
    );

    // Handshake and control strobes derived from the engine state.
    always_comb begin
        hs          = out_valid && out_ready;
        seq_restart = (state == ST_IDLE);
        seq_step    = (state == ST_PAIR) && hs && !plast;
        mac_en      = (state == ST_MAC);
        release_buf = (state == ST_PAIR) && hs && plast;
    end

    // Engine sequencing: dense words, then compute and emit each pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rd_sel <= 1'b0;
            ecnt   <= '0;
            chunk  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    ecnt <= '0;
                    if (full[rd_sel]) state <= ST_DENSE;
                end
                ST_DENSE: if (hs) begin
                    if (ecnt == EW'(DIM - 1)) begin
                        chunk <= '0;
                        state <= ST_MAC;
                    end else begin
                        ecnt <= ecnt + 1'b1;
                    end
                end
                ST_MAC: begin
                    if (chunk == KW'(CHUNKS - 1)) begin
                        chunk <= '0;
                        state <= ST_PAIR;
                    end else begin
                        chunk <= chunk + 1'b1;
                    end
                end
                ST_PAIR: if (hs) begin
                    if (plast) begin
                        rd_sel <= ~rd_sel;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_MAC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output word formatting.
    always_comb begin
        dense_elem = vec_a[int'(ecnt) * DW +: DW];
        shifted    = acc >>> OUT_SHIFT;
        out_valid  = (state == ST_DENSE) || (state == ST_PAIR);
        out_last   = (state == ST_PAIR) && plast;
        if (state == ST_DENSE)
            out_data = {{(OUT_W - DW){dense_elem[DW-1]}}, dense_elem};
        else
            out_data = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/ixn_unit_chk.sv
// Protocol checker for ixn_unit, bound to every instance.
// Tracks output words per sample and vectors held, from the ports only.
module ixn_unit_chk #(
    parameter int V     = 4,
    parameter int WORDS = 10,
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             out_last
);
    logic [15:0] wcnt;
    logic [15:0] held;

    // Count words within the current sample and vectors held inside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            held <= '0;
        end else begin
            if (out_valid && out_ready)
                wcnt <= out_last ? '0 : wcnt + 1'b1;
            held <= held + 16'(in_valid && in_ready)
                  - ((out_valid && out_ready && out_last) ? 16'(V) : 16'd0);
        end
    end

    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    a_r5_last_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |-> wcnt == 16'(WORDS - 1));

    a_r5_end_has_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && wcnt == 16'(WORDS - 1) |-> out_last);

    a_r7_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> held < 16'(2 * V));

    a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

bind ixn_unit ixn_unit_chk #(
    .V(NUM_TABLES + 1),
    .WORDS(DIM + NUM_TABLES * (NUM_TABLES + 1) / 2),
    .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
);

// File: tb/ixn_unit_test.sv
`timescale 1ns/1ps
// Self-checking bench for ixn_unit with its default configuration.
module ixn_unit_test;
    localparam int S      = 3;
    localparam int D      = 4;
    localparam int DW     = 16;
    localparam int LANES  = 2;
    localparam int OW     = 32;
    localparam int SH     = 0;
    localparam int V      = S + 1;
    localparam int CHUNKS = D / LANES;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [D*DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [OW-1:0] out_data;
    logic          out_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int mode   = 0;      // 0 ready always, 1 pseudo-random ready, 2 ready low
    logic [15:0] rlfsr = 16'h1d3b;
    logic [15:0] dlfsr = 16'hace1;

    logic [OW-1:0] exp_q [$];
    logic          last_q [$];
    logic          pair_q [$];
    int            vec [V][D];

    int prev_cyc = -1000;
    int prev_mode = -1;
    logic prev_was_last = 1'b1;

    ixn_unit #(.NUM_TABLES(S), .DIM(D), .DW(DW), .LANES(LANES),
               .OUT_W(OW), .OUT_SHIFT(SH)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Output monitor: set ready per mode, then compare accepted words.
    always @(negedge clk) begin
        if (rst_n) begin
            case (mode)
                0: out_ready = 1'b1;
                1: begin
                    rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
                    out_ready = rlfsr[0] | rlfsr[3];
                end
                default: out_ready = 1'b0;
            endcase
            #1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected word", out_data, '1);
                end else begin
                    logic [OW-1:0] e;
                    logic el, ep;
                    e  = exp_q.pop_front();
                    el = last_q.pop_front();
                    ep = pair_q.pop_front();
                    check(ep ? "R4 R3 pair value" : "R2 R1 dense word", out_data, e);
                    check("R5 last flag", OW'(out_last), OW'(el));
                    // R9: fixed compute spacing ahead of each pair word
                    if (ep && !prev_was_last && mode == 0 && prev_mode == 0)
                        check("R9 pair spacing", OW'(cyc - prev_cyc), OW'(CHUNKS + 1));
                    prev_was_last = el;
                end
                prev_cyc  = cyc;
                prev_mode = mode;
            end
        end
    end

    // Queue the expected words of the sample held in vec.
    task automatic expect_sample();
        for (int e = 0; e < D; e++) begin
            logic [DW-1:0] x;
            x = DW'(vec[0][e]);
            exp_q.push_back({{(OW-DW){x[DW-1]}}, x});
            last_q.push_back(1'b0);
            pair_q.push_back(1'b0);
        end
        for (int i = 0; i < V; i++) begin
            for (int j = i + 1; j < V; j++) begin
                longint s;
                s = 0;
                for (int e = 0; e < D; e++) s += longint'(vec[i][e]) * longint'(vec[j][e]);
                s = s >>> SH;
                exp_q.push_back(s[OW-1:0]);
                last_q.push_back((i == V - 2) && (j == V - 1));
                pair_q.push_back(1'b1);
            end
        end
    endtask

    // Drive the V vectors of vec, one per accepted beat.
    task automatic send_sample();
        expect_sample();
        for (int k = 0; k < V; k++) begin
            logic took;
            took = 1'b0;
            while (!took) begin
                @(negedge clk);
                in_valid = 1'b1;
                for (int e = 0; e < D; e++) in_data[e*DW +: DW] = DW'(vec[k][e]);
                #1;
                took = in_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 5000) begin
            @(posedge clk);
            guard++;
        end
        repeat (4) @(posedge clk);
    endtask

    task automatic fill_fixed(input int a, input int b);
        for (int k = 0; k < V; k++)
            for (int e = 0; e < D; e++)
                vec[k][e] = ((k + e) % 2 == 0) ? a : b;
    endtask

    task automatic fill_rand();
        for (int k = 0; k < V; k++)
            for (int e = 0; e < D; e++) begin
                dlfsr = {dlfsr[14:0], dlfsr[15] ^ dlfsr[13] ^ dlfsr[12] ^ dlfsr[10]};
                vec[k][e] = int'($signed(dlfsr ^ 16'h5a5a));
            end
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 in_ready after reset", OW'(in_ready), OW'(1));
        check("R8 out_valid after reset", OW'(out_valid), OW'(0));

        // Structured sweep, ready held high: values, order, spacing.
        mode = 0;
        for (int n = 0; n < 16; n++) begin
            for (int k = 0; k < V; k++)
                for (int e = 0; e < D; e++)
                    vec[k][e] = ((n * 7 + k * 3 + e * 5 + n * k * e) % 11) - 5;
            send_sample();
        end
        drain();

        // Extremes exercise full-width accumulation and wrap at OUT_W (R4).
        mode = 1;
        fill_fixed(32767, 32767);   send_sample();
        fill_fixed(-32768, -32768); send_sample();
        fill_fixed(32767, -32768);  send_sample();
        fill_fixed(0, 0);           send_sample();
        drain();

        // Random values with a stalling consumer (R6).
        for (int n = 0; n < 8; n++) begin
            fill_rand();
            send_sample();
        end
        drain();

        // Ping-pong: two samples load while the output is stalled (R7).
        mode = 2;
        fill_rand(); send_sample();
        fill_rand(); send_sample();
        repeat (3) @(negedge clk);
        #1;
        check("R7 in_ready low with both buffers held", OW'(in_ready), OW'(0));
        check("R7 output pending while stalled", OW'(out_valid), OW'(1));
        mode = 0;
        drain();
        @(negedge clk);
        #1;
        check("R7 in_ready back after drain", OW'(in_ready), OW'(1));
        check("R3 no extra words", OW'(out_valid), OW'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule